// File: doc/BRIEF.md
# Endpoint DMA Request Sequencer

This block drives the data-request handshake between one bulk endpoint buffer and a DMA engine that moves 16-bit words. A packet-done event from the packet engine raises a request flag, the DMA engine answers with word strobes, and the block tells the CPU through a single interrupt line when software attention is needed.

In per-packet mode the request flag follows each packet and stays up until the CPU clears it, and the interrupt mirrors the flag. In automatic mode (auto select and DMA enable both set) software loads a total byte count once. The flag then drops by itself each time one packet's worth of bytes has moved, and rises again on the next packet event. The interrupt stays low until the total is used up. In the IN direction with the null enable set, a transfer whose last packet exactly fills the maximum size is followed by a zero-length packet before completion is reported.

Top module: `ep_dreq_seq`

## Requirements
- R1: After reset, `dreq`, `irq` and `zlp_armed` are 0 and `remain` is 0.
- R2: In per-packet mode (`cfg_auto`=0 or `cfg_dma_en`=0), `pkt_done` sets `dreq` and only `cpu_clr` clears it; when both arrive in the same cycle `dreq` is set. `irq` equals `dreq` in this mode.
- R3: In per-packet mode, `dma_word` and `load` have no effect on `remain`.
- R4: In automatic mode, `load` sets `remain` to `load_total` and clears `irq`. For IN (`cfg_dir_in`=1) with a nonzero total, `dreq` rises at once. For OUT, `dreq` stays 0 until `pkt_done`.
- R5: In automatic mode, each `dma_word` while `dreq`=1 lowers `remain` by 2, or to 0 when 1 byte is left.
- R6: In automatic mode, `dreq` drops by itself after min(`cfg_pkt_size`, bytes remaining at packet start) bytes, i.e. that count rounded up to whole words.
- R7: In automatic mode, `pkt_done` raises `dreq` again while `remain` is nonzero, and `irq` stays 0 until the transfer is complete.
- R8: In automatic mode, `irq` rises when `remain` reaches 0, or at once on a load of 0, unless a zero-length packet is due. `irq` stays high until `cpu_clr`. Further `pkt_done` events do not raise `dreq`.
- R9: With IN, `cfg_null_en`=1 and a last packet of exactly `cfg_pkt_size` bytes, `irq` stays 0 after the last word. The next `pkt_done` raises `zlp_armed`, and the one after that drops `zlp_armed` and raises `irq`. `dreq` stays 0 throughout.
- R10: For OUT, or with `cfg_null_en`=0, `zlp_armed` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_auto | input | 1 | 1 selects automatic mode (with cfg_dma_en) |
| cfg_dma_en | input | 1 | DMA enable |
| cfg_dir_in | input | 1 | 1 = IN (device to host), 0 = OUT |
| cfg_null_en | input | 1 | Allows the trailing zero-length packet |
| cfg_pkt_size | input | PKT_W | Maximum packet size in bytes (even) |
| load | input | 1 | Pulse: start an automatic transfer |
| load_total | input | CNT_W | Total bytes for the transfer |
| pkt_done | input | 1 | Packet-done event from the packet engine |
| dma_word | input | 1 | One 16-bit word moved by the DMA engine |
| cpu_clr | input | 1 | CPU clear of the flag or interrupt |
| dreq | output | 1 | Data request to the DMA engine |
| irq | output | 1 | CPU interrupt |
| zlp_armed | output | 1 | Buffer holds a zero-length packet for the next IN |
| remain | output | CNT_W | Bytes still to move |

## Verification
The bench builds the block with CNT_W=8 and PKT_W=4, so packet sizes of 2 to 8 bytes and totals of 0 to 19 bytes can all be swept in both directions, with the null enable on and off. That reaches odd totals, empty loads, short last packets and exact multiples of the packet size, which is where the zero-length packet appears. For each case the bench computes the word count per packet and the expected completion path by arithmetic. Separate cases exercise per-packet mode, including set-versus-clear priority and the ignored counters.

// File: rtl/ep_dreq_seq.sv
module ep_dreq_seq #(
  parameter int CNT_W = 16,
  parameter int PKT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_auto,
  input  logic             cfg_dma_en,
  input  logic             cfg_dir_in,
  input  logic             cfg_null_en,
  input  logic [PKT_W-1:0] cfg_pkt_size,
  input  logic             load,
  input  logic [CNT_W-1:0] load_total,
  input  logic             pkt_done,
  input  logic             dma_word,
  input  logic             cpu_clr,
  output logic             dreq,
  output logic             irq,
  output logic             zlp_armed,
  output logic [CNT_W-1:0] remain
);

  logic             dreq_q, done_q, zarm_q, zsend_q;
  logic [CNT_W-1:0] rem_q;
  logic [PKT_W:0]   pcnt_q;

  wire             auto_m = cfg_auto & cfg_dma_en;
  wire [1:0]       step   = (rem_q >= CNT_W'(2)) ? 2'd2 : rem_q[1:0];
  wire [CNT_W-1:0] rem_nx = rem_q - CNT_W'(step);
  wire [PKT_W:0]   pbytes = pcnt_q + (PKT_W+1)'(step);
  wire [PKT_W:0]   psize  = {1'b0, cfg_pkt_size};
  wire             pkt_full = (pbytes == psize);
  wire             pkt_end  = (pbytes >= psize) || (rem_nx == '0);

  assign dreq      = dreq_q;
  assign irq       = auto_m ? done_q : dreq_q;
  assign zlp_armed = zsend_q;
  assign remain    = rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dreq_q  <= 1'b0;
      done_q  <= 1'b0;
      zarm_q  <= 1'b0;
      zsend_q <= 1'b0;
      rem_q   <= '0;
      pcnt_q  <= '0;
    end else if (!auto_m) begin
      done_q  <= 1'b0;
      zarm_q  <= 1'b0;
      zsend_q <= 1'b0;
      if (pkt_done)     dreq_q <= 1'b1;
      else if (cpu_clr) dreq_q <= 1'b0;
    end else if (load) begin
      rem_q   <= load_total;
      pcnt_q  <= '0;
      zarm_q  <= 1'b0;
      zsend_q <= 1'b0;
      done_q  <= (load_total == '0);
      dreq_q  <= cfg_dir_in && (load_total != '0);
    end else begin
      if (cpu_clr) done_q <= 1'b0;
      if (dreq_q && dma_word) begin
        rem_q  <= rem_nx;
        pcnt_q <= pkt_end ? '0 : pbytes;
        if (pkt_end) dreq_q <= 1'b0;
        if (rem_nx == '0) begin
          if (pkt_full && cfg_dir_in && cfg_null_en) zarm_q <= 1'b1;
          else                                       done_q <= 1'b1;
        end
      end else if (pkt_done) begin
        if (zsend_q) begin
          zsend_q <= 1'b0;
          done_q  <= 1'b1;
        end else if (zarm_q) begin
          zarm_q  <= 1'b0;
          zsend_q <= 1'b1;
        end else if (rem_q != '0) begin
          dreq_q  <= 1'b1;
        end
      end
    end
  end

  AST_PP_REM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_m |=> rem_q == $past(rem_q)); // R3
  AST_REM_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_m && !load) |=> rem_q <= $past(rem_q)); // R5
  AST_LAST_WORD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_m && !load && dreq_q && dma_word && rem_q <= CNT_W'(2)) |=> !dreq_q); // R6
  AST_IRQ_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_m && irq) |-> rem_q == '0); // R8
  AST_ZLP_NO_DREQ: assert property (@(posedge clk) disable iff (!rst_n)
    (zarm_q || zsend_q) |-> !dreq_q); // R9
  AST_ZLP_IN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zsend_q) |-> cfg_dir_in && cfg_null_en); // R10

endmodule

// File: tb/test_ep_dreq_seq.sv
module test_ep_dreq_seq;
  localparam int CW = 8;
  localparam int PW = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_auto = 0, cfg_dma_en = 0, cfg_dir_in = 0, cfg_null_en = 0;
  logic [PW-1:0] cfg_pkt_size = 0;
  logic load = 0, pkt_done = 0, dma_word = 0, cpu_clr = 0;
  logic [CW-1:0] load_total = 0;
  logic dreq, irq, zlp_armed;
  logic [CW-1:0] remain;
  int nchk = 0, nerr = 0, cyc = 0;

  always #5 clk = ~clk;

  ep_dreq_seq #(.CNT_W(CW), .PKT_W(PW)) i_ep_dreq_seq (
    .clk(clk), .rst_n(rst_n), .cfg_auto(cfg_auto), .cfg_dma_en(cfg_dma_en),
    .cfg_dir_in(cfg_dir_in), .cfg_null_en(cfg_null_en), .cfg_pkt_size(cfg_pkt_size),
    .load(load), .load_total(load_total), .pkt_done(pkt_done), .dma_word(dma_word),
    .cpu_clr(cpu_clr), .dreq(dreq), .irq(irq), .zlp_armed(zlp_armed), .remain(remain));

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic done_p();
    @(negedge clk) pkt_done = 1; @(negedge clk) pkt_done = 0;
  endtask
  task automatic word_p();
    @(negedge clk) dma_word = 1; @(negedge clk) dma_word = 0;
  endtask
  task automatic clr_p();
    @(negedge clk) cpu_clr = 1; @(negedge clk) cpu_clr = 0;
  endtask
  task automatic load_p(input int t);
    @(negedge clk) begin load = 1; load_total = CW'(t); end
    @(negedge clk) load = 0;
  endtask

  task automatic run(input int dir, input int nul, input int psz, input int tot);
    int rem, b, words, rexp;
    bit zexp;
    cfg_auto = 1; cfg_dma_en = 1;
    cfg_dir_in = dir[0]; cfg_null_en = nul[0]; cfg_pkt_size = PW'(psz);
    load_p(tot);
    chk("R4 remain", int'(remain), tot);
    chk("R4 dreq", int'(dreq), (dir == 1 && tot != 0) ? 1 : 0);
    rem = tot; rexp = tot;
    while (rem > 0) begin
      if (dir == 0) begin
        chk("R4 out idle", int'(dreq), 0);
        done_p();
      end
      chk("R7 dreq", int'(dreq), 1);
      b = (rem < psz) ? rem : psz;
      words = 0;
      while (dreq && words < 100) begin
        word_p(); words++;
        rexp = (rexp >= 2) ? rexp - 2 : 0;
        chk("R5 remain", int'(remain), rexp);
      end
      chk("R6 words", words, (b + 1) / 2);
      rem -= b;
      if (rem > 0) begin
        chk("R7 irq", int'(irq), 0);
        if (dir == 1) done_p();
      end
    end
    zexp = (dir == 1 && nul == 1 && tot > 0 && tot % psz == 0);
    if (zexp) begin
      chk("R9 irq held", int'(irq), 0);
      done_p();
      chk("R9 zlp", int'(zlp_armed), 1);
      chk("R9 dreq", int'(dreq), 0);
      done_p();
      chk("R9 zlp sent", int'(zlp_armed), 0);
      chk("R9 irq", int'(irq), 1);
    end else begin
      chk("R8 irq", int'(irq), 1);
      done_p();
      chk("R10 zlp", int'(zlp_armed), 0);
      chk("R8 no dreq", int'(dreq), 0);
    end
    chk("R8 remain", int'(remain), 0);
    clr_p();
    chk("R8 clr", int'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 dreq", int'(dreq), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 zlp", int'(zlp_armed), 0);
    chk("R1 remain", int'(remain), 0);
    @(negedge clk) rst_n = 1;

    for (int sel = 0; sel < 2; sel++) begin
      cfg_auto = 1; cfg_dma_en = 1; cfg_dir_in = 0;
      load_p(10);
      cfg_auto = sel[0]; cfg_dma_en = ~sel[0];
      done_p();
      chk("R2 set", int'(dreq), 1);
      chk("R2 irq", int'(irq), 1);
      word_p(); word_p();
      chk("R3 word ignored", int'(remain), 10);
      load_p(4);
      chk("R3 load ignored", int'(remain), 10);
      done_p();
      chk("R2 still set", int'(dreq), 1);
      clr_p();
      chk("R2 clear", int'(dreq), 0);
      chk("R2 irq clr", int'(irq), 0);
      @(negedge clk) begin pkt_done = 1; cpu_clr = 1; end
      @(negedge clk) begin pkt_done = 0; cpu_clr = 0; end
      chk("R2 set wins", int'(dreq), 1);
      clr_p();
    end

    for (int dir = 0; dir < 2; dir++)
      for (int nul = 0; nul < 2; nul++)
        for (int psz = 2; psz <= 8; psz += 2)
          for (int tot = 0; tot < 20; tot++)
            run(dir, nul, psz, tot);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule